// File: doc/BRIEF.md
# SD Command Issue and Response Register Block

This block sits between a host CPU's register bus and an SD command engine. Software loads a 16-bit command word and a 32-bit argument split into an upper and a lower half register. It then writes a control register that selects the response type and the data direction. That control write launches the command: the block presents the command, argument, response type and direction to the engine together with a one-cycle request pulse.

When the engine reports completion, the block records the engine's six error flags and raises a done flag in a status register. It also captures the response into a word buffer. Software polls status until done is set and retries the command if any error flag is nonzero. It then drains the response through a single read port, most significant word first. Each read of that port steps to the next word. The number of words depends on the response type, and reads beyond the last valid word return zero.

All registers are 16 bits wide and are addressed by word offset: 0 status, 1 control, 2 command, 3 argument bits 31:16, 4 argument bits 15:0, 5 response. Register reads return data one cycle after the read strobe.

Top module: `sdcmd_regs`

## Requirements
- R1: After reset, the status register reads 0, a response read returns 0 and `eng_req_o` is low.
- R2: The command register (offset 2) drives `eng_cmd_o`. The upper argument register (offset 3) drives `eng_arg_o[31:16]` and the lower one (offset 4) drives `eng_arg_o[15:0]`. All three read back the value written to them.
- R3: A write to the control register (offset 1) raises `eng_req_o` for exactly the following cycle. At that point `eng_rtype_o` equals control bits 2:0 and `eng_dir_o` equals control bit 3 (0 read, 1 write).
- R4: When `eng_done_i` is sampled high while a command is outstanding, status bit 13 becomes 1 and stays 1 until the next control write.
- R5: At that same completion, status bits 5:0 take the value of `eng_err_i`. All other status bits read 0.
- R6: A control write clears the done flag, the error bits and the response read position, and discards the previous response.
- R7: Response type 2 yields 8 words taken from `eng_resp_i[127:0]`, with bits 127:112 read first and bits 15:0 read last.
- R8: Response types 1 and 3 yield 3 words taken from `eng_resp_i[47:0]`, with bits 47:32 read first.
- R9: Response type 0 yields no words. Any response read past the last valid word returns 0 and does not move the read position.
- R10: `eng_done_i` has no effect on status or on the response buffer when no command is outstanding.
- R11: Reads of registers other than the response register do not move the response read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after the strobe |
| eng_req_o | output | 1 | One-cycle command launch to the engine |
| eng_cmd_o | output | 16 | Command word |
| eng_arg_o | output | 32 | Command argument |
| eng_rtype_o | output | 3 | Response type |
| eng_dir_o | output | 1 | Data direction |
| eng_done_i | input | 1 | Engine completion strobe |
| eng_err_i | input | 6 | Engine error flags at completion |
| eng_resp_i | input | 128 | Response bits, meaningful at completion |

## Verification
The bench builds the block with its default parameters: a long response of 8 words, a short response of 3 words and 6 error flags. This setting makes both response lengths and the no-response type reachable, so both ends of the buffer can be tested. The bench drains each response one read past its end and restarts a command while a response is only partly drained. It also injects a completion strobe while nothing is outstanding, and mixes status reads into a drain to show that they leave the read position unchanged.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int unsigned DW     = 16;
  localparam int unsigned ADDR_W = 3;
  typedef logic [ADDR_W-1:0] reg_addr_t;
  localparam reg_addr_t OFS_STATUS = 3'd0;
  localparam reg_addr_t OFS_CTRL   = 3'd1;
  localparam reg_addr_t OFS_CMD    = 3'd2;
  localparam reg_addr_t OFS_ARG_HI = 3'd3;
  localparam reg_addr_t OFS_ARG_LO = 3'd4;
  localparam reg_addr_t OFS_RESP   = 3'd5;
  localparam int unsigned DONE_BIT = 13;
  typedef enum logic [2:0] {
    RT_NONE  = 3'd0,
    RT_SHORT = 3'd1,
    RT_LONG  = 3'd2,
    RT_OCR   = 3'd3
  } rtype_e;
endpackage

// File: rtl/sdcmd_cmd_regs.sv
module sdcmd_cmd_regs
  import sdcmd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  reg_addr_t     addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          start_o,
  output logic          req_o,
  output logic [DW-1:0] cmd_o,
  output logic [DW-1:0] arg_hi_o,
  output logic [DW-1:0] arg_lo_o,
  output logic [DW-1:0] ctrl_o
);
  logic [DW-1:0] cmd_q, arg_hi_q, arg_lo_q, ctrl_q;
  logic          req_q;

  assign start_o = wr_en_i && (addr_i == OFS_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      arg_hi_q <= '0;
      arg_lo_q <= '0;
      ctrl_q   <= '0;
      req_q    <= 1'b0;
    end else begin
      req_q <= start_o;
      if (wr_en_i) begin
        unique case (addr_i)
          OFS_CMD:    cmd_q    <= wdata_i;
          OFS_ARG_HI: arg_hi_q <= wdata_i;
          OFS_ARG_LO: arg_lo_q <= wdata_i;
          OFS_CTRL:   ctrl_q   <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign req_o    = req_q;
  assign cmd_o    = cmd_q;
  assign arg_hi_o = arg_hi_q;
  assign arg_lo_o = arg_lo_q;
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/sdcmd_status.sv
module sdcmd_status #(
  parameter int unsigned ERR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             eng_done_i,
  input  logic [ERR_W-1:0] eng_err_i,
  output logic             capture_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [ERR_W-1:0] err_o
);
  logic             busy_q, done_q;
  logic [ERR_W-1:0] err_q;

  // a launch in the same cycle as a completion wins
  assign capture_o = busy_q && eng_done_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      err_q  <= '0;
    end else if (capture_o) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
      err_q  <= eng_err_i;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/sdcmd_resp_buf.sv
module sdcmd_resp_buf
  import sdcmd_pkg::*;
#(
  parameter int unsigned LONG_W  = 8,
  parameter int unsigned SHORT_W = 3,
  localparam int unsigned PTR_W  = $clog2(LONG_W + 1),
  localparam int unsigned IDX_W  = (LONG_W > 1) ? $clog2(LONG_W) : 1,
  localparam int unsigned RESP_B = LONG_W * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              capture_i,
  input  logic [2:0]        rtype_i,
  input  logic [RESP_B-1:0] resp_i,
  input  logic              pop_i,
  output logic [DW-1:0]     word_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [PTR_W-1:0]  len_o
);
  logic [DW-1:0]    words_q [LONG_W];
  logic [DW-1:0]    short_w [LONG_W];
  logic [PTR_W-1:0] ptr_q, len_q, len_d;
  logic             is_long;

  assign is_long = (rtype_i == RT_LONG);

  always_comb begin
    unique case (rtype_i)
      RT_LONG:          len_d = PTR_W'(LONG_W);
      RT_SHORT, RT_OCR: len_d = PTR_W'(SHORT_W);
      default:          len_d = '0;
    endcase
  end

  for (genvar i = 0; i < LONG_W; i++) begin : g_word
    if (i < SHORT_W) begin : g_short
      assign short_w[i] = resp_i[(SHORT_W-i)*DW-1 -: DW];
    end else begin : g_pad
      assign short_w[i] = '0;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        words_q[i] <= '0;
      else if (capture_i) words_q[i] <= is_long ? resp_i[(LONG_W-i)*DW-1 -: DW] : short_w[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      len_q <= '0;
    end else if (clear_i) begin
      ptr_q <= '0;
      len_q <= '0;
    end else if (capture_i) begin
      ptr_q <= '0;
      len_q <= len_d;
    end else if (pop_i && (ptr_q < len_q)) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign word_o = (ptr_q < len_q) ? words_q[ptr_q[IDX_W-1:0]] : '0;
  assign ptr_o  = ptr_q;
  assign len_o  = len_q;
endmodule

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
  import sdcmd_pkg::*;
#(
  parameter int unsigned LONG_W  = 8,
  parameter int unsigned SHORT_W = 3,
  parameter int unsigned ERR_W   = 6,
  localparam int unsigned PTR_W  = $clog2(LONG_W + 1),
  localparam int unsigned RESP_B = LONG_W * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              eng_req_o,
  output logic [DW-1:0]     eng_cmd_o,
  output logic [2*DW-1:0]   eng_arg_o,
  output logic [2:0]        eng_rtype_o,
  output logic              eng_dir_o,
  input  logic              eng_done_i,
  input  logic [ERR_W-1:0]  eng_err_i,
  input  logic [RESP_B-1:0] eng_resp_i
);
  logic             start, capture, busy, done;
  logic [ERR_W-1:0] err;
  logic [DW-1:0]    cmd, arg_hi, arg_lo, ctrl, resp_word, status, rd_d, rdata_q;
  logic [PTR_W-1:0] rd_ptr, rd_len;
  logic             pop;

  sdcmd_cmd_regs u_cmd (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .start_o(start), .req_o(eng_req_o), .cmd_o(cmd),
    .arg_hi_o(arg_hi), .arg_lo_o(arg_lo), .ctrl_o(ctrl)
  );

  sdcmd_status #(.ERR_W(ERR_W)) u_stat (
    .clk_i, .rst_ni, .start_i(start), .eng_done_i, .eng_err_i,
    .capture_o(capture), .busy_o(busy), .done_o(done), .err_o(err)
  );

  assign pop = rd_en_i && (addr_i == OFS_RESP);

  sdcmd_resp_buf #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_resp (
    .clk_i, .rst_ni, .clear_i(start), .capture_i(capture),
    .rtype_i(ctrl[2:0]), .resp_i(eng_resp_i), .pop_i(pop),
    .word_o(resp_word), .ptr_o(rd_ptr), .len_o(rd_len)
  );

  always_comb begin
    status = '0;
    status[ERR_W-1:0] = err;
    status[DONE_BIT]  = done;
  end

  always_comb begin
    unique case (addr_i)
      OFS_STATUS: rd_d = status;
      OFS_CTRL:   rd_d = ctrl;
      OFS_CMD:    rd_d = cmd;
      OFS_ARG_HI: rd_d = arg_hi;
      OFS_ARG_LO: rd_d = arg_lo;
      OFS_RESP:   rd_d = resp_word;
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_d;
  end

  assign rdata_o     = rdata_q;
  assign eng_cmd_o   = cmd;
  assign eng_arg_o   = {arg_hi, arg_lo};
  assign eng_rtype_o = ctrl[2:0];
  assign eng_dir_o   = ctrl[3];
endmodule

// File: rtl/sdcmd_regs_chk.sv
module sdcmd_regs_chk
  import sdcmd_pkg::*;
#(
  parameter int unsigned ERR_W = 6,
  parameter int unsigned PTR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              eng_req_i,
  input logic              eng_done_i,
  input logic [ERR_W-1:0]  eng_err_i,
  input logic              busy_i,
  input logic              done_i,
  input logic [ERR_W-1:0]  err_i,
  input logic [PTR_W-1:0]  ptr_i,
  input logic [PTR_W-1:0]  len_i
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (addr_i == OFS_CTRL);

  p_req_from_ctrl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_i |-> $past(ctrl_wr));

  p_done_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && eng_done_i && !ctrl_wr) |=> done_i);

  p_err_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && eng_done_i && !ctrl_wr) |=> (err_i == $past(eng_err_i)));

  p_start_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (!done_i && err_i == '0 && ptr_i == '0 && len_i == '0));

  p_ptr_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_i <= len_i);

  p_idle_done_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !ctrl_wr) |=> ($stable(done_i) && $stable(err_i) && $stable(len_i)));
endmodule

bind sdcmd_regs sdcmd_regs_chk #(.ERR_W(ERR_W), .PTR_W(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .eng_req_i(eng_req_o), .eng_done_i(eng_done_i), .eng_err_i(eng_err_i),
  .busy_i(busy), .done_i(done), .err_i(err), .ptr_i(rd_ptr), .len_i(rd_len)
);

// File: tb/tb_sdcmd_regs.sv
`timescale 1ns/1ps
module tb_sdcmd_regs;
  localparam int A_STAT = 0, A_CTRL = 1, A_CMD = 2, A_AHI = 3, A_ALO = 4, A_RESP = 5;

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic         wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0]   addr_i = '0;
  logic [15:0]  wdata_i = '0;
  logic [15:0]  rdata_o;
  logic         eng_req_o, eng_dir_o;
  logic [15:0]  eng_cmd_o;
  logic [31:0]  eng_arg_o;
  logic [2:0]   eng_rtype_o;
  logic         eng_done_i = 1'b0;
  logic [5:0]   eng_err_i = '0;
  logic [127:0] eng_resp_i = '0;

  int checks = 0, errors = 0;

  sdcmd_regs dut (.*);

  always #4 clk_i = ~clk_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(int a, logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 3'(a); wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic bus_read(int a, output logic [15:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = 3'(a);
    @(posedge clk_i); #1;
    d = rdata_o;
    rd_en_i = 1'b0;
  endtask

  // load registers and launch; checks the engine view (R2, R3)
  task automatic launch(logic [15:0] cmd, logic [31:0] arg, logic [15:0] ctrl);
    bus_write(A_CMD, cmd);
    bus_write(A_AHI, arg[31:16]);
    bus_write(A_ALO, arg[15:0]);
    bus_write(A_CTRL, ctrl);
    check("R3 req pulse", 32'(eng_req_o), 32'd1);
    check("R3 rtype", 32'(eng_rtype_o), 32'(ctrl[2:0]));
    check("R3 dir", 32'(eng_dir_o), 32'(ctrl[3]));
    check("R2 cmd", 32'(eng_cmd_o), 32'(cmd));
    check("R2 arg", eng_arg_o, arg);
    @(posedge clk_i); #1;
    check("R3 req single cycle", 32'(eng_req_o), 32'd0);
  endtask

  task automatic complete(logic [5:0] err, logic [127:0] resp);
    @(negedge clk_i);
    eng_done_i = 1'b1; eng_err_i = err; eng_resp_i = resp;
    @(posedge clk_i); #1;
    eng_done_i = 1'b0; eng_resp_i = '0; eng_err_i = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 req", 32'(eng_req_o), 32'd0);
    bus_read(A_STAT, d); check("R1 status", 32'(d), 32'd0);
    bus_read(A_RESP, d); check("R1 resp", 32'(d), 32'd0);
  endtask

  task automatic t_readback();
    logic [15:0] d;
    bus_write(A_CMD, 16'h0c12);
    bus_write(A_AHI, 16'hbeef);
    bus_write(A_ALO, 16'h1234);
    bus_read(A_CMD, d); check("R2 cmd readback", 32'(d), 32'h0c12);
    bus_read(A_AHI, d); check("R2 arg hi readback", 32'(d), 32'hbeef);
    bus_read(A_ALO, d); check("R2 arg lo readback", 32'(d), 32'h1234);
  endtask

  task automatic t_long();
    logic [15:0] d;
    logic [127:0] r = 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff;
    launch(16'h0002, 32'h0000_0000, 16'h0002);
    bus_read(A_STAT, d); check("R6 done clear while pending", 32'(d), 32'd0);
    complete(6'h00, r);
    bus_read(A_STAT, d); check("R4 done set", 32'(d), 32'h2000);
    for (int i = 0; i < 8; i++) begin
      bus_read(A_RESP, d);
      check("R7 long word", 32'(d), 32'(r[127-16*i -: 16]));
    end
    bus_read(A_RESP, d); check("R9 past end long", 32'(d), 32'd0);
    bus_read(A_STAT, d); check("R4 done held", 32'(d), 32'h2000);
  endtask

  task automatic t_short(logic [2:0] rt, logic [5:0] err);
    logic [15:0] d;
    logic [127:0] r = 128'hdead_beef_cafe_f00d_a5a5_1357_2468_9abc;
    launch(16'h0029, 32'h8010_0000, {12'h0, 1'b1, rt});
    complete(err, r);
    bus_read(A_STAT, d); check("R5 status error", 32'(d), 32'h2000 | 32'(err));
    for (int i = 0; i < 3; i++) begin
      bus_read(A_RESP, d);
      check("R8 short word", 32'(d), 32'(r[47-16*i -: 16]));
      if (i == 0) begin
        bus_read(A_STAT, d); check("R11 status read", 32'(d), 32'h2000 | 32'(err));
      end
    end
    bus_read(A_RESP, d); check("R9 past end short", 32'(d), 32'd0);
    bus_read(A_RESP, d); check("R9 past end again", 32'(d), 32'd0);
  endtask

  task automatic t_none();
    logic [15:0] d;
    launch(16'h0000, 32'h0, 16'h0000);
    complete(6'h00, {8{16'hffff}});
    bus_read(A_STAT, d); check("R4 done type0", 32'(d), 32'h2000);
    bus_read(A_RESP, d); check("R9 no words type0", 32'(d), 32'd0);
  endtask

  task automatic t_restart();
    logic [15:0] d;
    logic [127:0] r1 = {8{16'h1111}};
    logic [127:0] r2 = 128'h0102_0304_0506_0708_090a_0b0c_0d0e_0f10;
    launch(16'h0009, 32'h0001_0000, 16'h0002);
    complete(6'h21, r1);
    bus_read(A_RESP, d); check("R7 first before restart", 32'(d), 32'h1111);
    bus_read(A_RESP, d);
    launch(16'h0009, 32'h0001_0000, 16'h0002);
    bus_read(A_STAT, d); check("R6 status cleared", 32'(d), 32'd0);
    bus_read(A_RESP, d); check("R6 old response gone", 32'(d), 32'd0);
    complete(6'h00, r2);
    bus_read(A_RESP, d); check("R6 pointer restarted", 32'(d), 32'h0102);
  endtask

  task automatic t_idle_done();
    logic [15:0] d;
    logic [127:0] r = 128'h0000_0000_0000_0000_0000_aaaa_bbbb_cccc;
    launch(16'h0003, 32'h0, 16'h0001);
    complete(6'h00, r);
    complete(6'h3f, {8{16'h7777}});
    bus_read(A_STAT, d); check("R10 status unchanged", 32'(d), 32'h2000);
    bus_read(A_RESP, d); check("R10 response unchanged", 32'(d), 32'haaaa);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    t_reset();
    t_readback();
    t_long();
    t_short(3'd1, 6'h15);
    t_short(3'd3, 6'h00);
    t_none();
    t_restart();
    t_idle_done();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule